// File: doc/BRIEF.md
# Chunk-Paced Disk Transfer Sequencer

This block is the control engine that moves one disk command's data as a series of chunks handed to it by a DMA channel. A start pulse arms it for a new command. The start loads a signed remaining-byte count and clears a running byte index. Each chunk descriptor the channel offers (memory address plus length) becomes a single read or write request to a storage port. The request carries the storage byte offset worked out from the command's starting position and the index. The sequencer then waits for the storage side to complete.

Two addressing flavours exist. Sector mode uses 512-byte units and honours the command's direction. Packet mode uses 2048-byte blocks and always reads. Packet mode also has a raw-copy path, picked when the block address is all ones: one short read, and then the command completes at once. The sequencer only takes chunks while its armed flag is set, so a chunk that arrives early waits at the port until the next start. Every pass over a chunk ends with exactly one pulse on the DMA-end output. A pass that also finishes the command is flagged with the drive interrupt (sector mode), a command-OK pulse (packet mode) or a DMA error pulse.

Top module: `xfer_chunk_seq`

## Requirements
- R1: A start pulse while no chunk is being handled arms the sequencer (`active_o` high on the next cycle), clears the byte index and sets the remaining count to `sec_count_i`×512 in sector mode (`mode_pkt_i`=0) or `pkt_bytes_i` in packet mode (`mode_pkt_i`=1).
- R2: In sector mode a request's `req_offset_o` equals `sec_num_i`×512 plus the byte index.
- R3: In packet mode (block address not all ones) a request's `req_offset_o` equals `blk_addr_i`×2048 plus the byte index.
- R4: Each non-raw request carries the chunk's address and full length. It lowers the remaining count and raises the byte index by that length, so the next request's offset is higher by that length.
- R5: `chunk_ready_o` stays low while the sequencer is not armed. No chunk is taken, no request is issued, `processing_o` stays low and no DMA-end pulse appears until a start arms it. Then the waiting chunk is taken.
- R6: When a chunk pass finds the remaining count zero or negative, either on arrival or after its request completes, the command ends. `dma_end_o` pulses together with `drive_irq_o` (sector mode) or `cmd_ok_o` (packet mode), and `active_o` falls.
- R7: A chunk of length zero issues no request. It only pulses `dma_end_o`, and the sequencer stays armed.
- R8: In packet mode with `blk_addr_i` all ones, a chunk issues one read with offset 0 and length min(remaining, chunk length). Its completion pulses `cmd_ok_o` with `dma_end_o` and disarms.
- R9: A completion with `cpl_err_i`=1 pulses `dma_err_o` with `dma_end_o` and disarms, with no `drive_irq_o` or `cmd_ok_o`.
- R10: `req_valid_o` and its fields hold steady until `req_ready_i`. Each taken chunk produces exactly one single-cycle `dma_end_o` pulse.
- R11: `req_write_o` is 1 for a write and 0 for a read. It follows `dir_wr_i` latched at start in sector mode and is always 0 in packet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm for a new command (pulse) |
| mode_pkt_i | input | 1 | 1 = packet mode, 0 = sector mode |
| dir_wr_i | input | 1 | 1 = write to storage (sector mode) |
| sec_count_i | input | CNT_W | Sector count of the command |
| sec_num_i | input | SEC_W | Starting sector number |
| pkt_bytes_i | input | PKT_W | Packet transfer size in bytes |
| blk_addr_i | input | LBA_W | Packet block address (all ones = raw copy) |
| chunk_valid_i | input | 1 | Chunk descriptor offered |
| chunk_ready_o | output | 1 | Chunk descriptor taken |
| chunk_addr_i | input | AW | Chunk memory address |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| req_valid_o | output | 1 | Storage request valid |
| req_ready_i | input | 1 | Storage request accepted |
| req_write_o | output | 1 | Request direction, 1 = write |
| req_offset_o | output | OFF_W | Storage byte offset |
| req_addr_o | output | AW | Memory address of request |
| req_len_o | output | LEN_W | Request length in bytes |
| cpl_done_i | input | 1 | Storage completion pulse |
| cpl_err_i | input | 1 | Completion carries an error |
| active_o | output | 1 | Armed flag |
| processing_o | output | 1 | A chunk is being handled |
| dma_end_o | output | 1 | End of the current chunk pass |
| drive_irq_o | output | 1 | Sector-mode command complete (ready status) |
| cmd_ok_o | output | 1 | Packet-mode command complete |
| dma_err_o | output | 1 | Command aborted on storage error |

## Verification
The bench offers a chunk before any start. A sequencer that ignored the armed flag would take it early and issue a request at a stale offset. It drives chunks that end the count exactly, overshoot it, or leave bytes over. A design that compared remaining as unsigned, or ended on the wrong pass, would miss the interrupt or raise it one chunk early. Zero-length chunks, raw copies shorter and longer than the remaining count, and an error completion are each checked. Any of these routed to the wrong exit would show up as a wrong or missing request, a doubled or absent DMA-end pulse, or the wrong completion flag.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    localparam int SECTOR_SHIFT = 9;
    localparam int BLOCK_SHIFT  = 11;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVAL,
        S_REQ,
        S_WAIT
    } seq_state_e;

    typedef struct packed {
        logic dma_end;
        logic irq;
        logic ok;
        logic err;
    } seq_evt_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/xfer_seq_count.sv
module xfer_seq_count
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PKT_W = 24,
    parameter int LEN_W = 16,
    parameter int REM_W = 28
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    pkt_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [PKT_W-1:0]        pkt_bytes_i,
    input  logic                    consume_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic signed [REM_W-1:0] rem_o,
    output logic [REM_W-1:0]        idx_o,
    output logic                    rem_le0_o
);
    logic signed [REM_W-1:0] rem_q;
    logic [REM_W-1:0]        idx_q;
    logic signed [REM_W-1:0] len_s;

    assign len_s = $signed(REM_W'(len_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            rem_q <= pkt_i ? $signed(REM_W'(pkt_bytes_i))
                           : $signed(REM_W'(cnt_i) << SECTOR_SHIFT);
            idx_q <= '0;
        end else if (consume_i) begin
            rem_q <= rem_q - len_s;
            idx_q <= idx_q + REM_W'(len_i);
        end
    end

    assign rem_o     = rem_q;
    assign idx_o     = idx_q;
    assign rem_le0_o = rem_q[REM_W-1] || (rem_q == '0);

endmodule

// File: rtl/xfer_seq_offset.sv
module xfer_seq_offset
    import xfer_seq_pkg::*;
#(
    parameter int SEC_W = 28,
    parameter int LBA_W = 32,
    parameter int REM_W = 28,
    parameter int OFF_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [LBA_W-1:0] lba_i,
    input  logic             pkt_i,
    input  logic [REM_W-1:0] idx_i,
    output logic [OFF_W-1:0] off_o,
    output logic             raw_o
);
    logic [SEC_W-1:0] sec_q;
    logic [LBA_W-1:0] lba_q;
    logic [OFF_W-1:0] base;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            lba_q <= '0;
        end else if (load_i) begin
            sec_q <= sec_i;
            lba_q <= lba_i;
        end
    end

    always_comb begin
        if (pkt_i) base = OFF_W'(lba_q) << BLOCK_SHIFT;
        else       base = OFF_W'(sec_q) << SECTOR_SHIFT;
    end

    assign off_o = base + OFF_W'(idx_i);
    assign raw_o = pkt_i && (lba_q == '1);

endmodule

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
    import xfer_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int AW    = 32,
    parameter int REM_W = 28,
    parameter int OFF_W = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    pkt_i,
    input  logic                    wr_i,
    input  logic                    chunk_valid_i,
    output logic                    chunk_ready_o,
    input  logic [AW-1:0]           chunk_addr_i,
    input  logic [LEN_W-1:0]        chunk_len_i,
    input  logic signed [REM_W-1:0] rem_i,
    input  logic                    rem_le0_i,
    input  logic                    raw_i,
    input  logic [OFF_W-1:0]        off_i,
    output logic                    load_o,
    output logic                    consume_o,
    output logic [LEN_W-1:0]        len_o,
    output logic                    pkt_o,
    output logic                    req_valid_o,
    input  logic                    req_ready_i,
    output logic                    req_write_o,
    output logic [OFF_W-1:0]        req_offset_o,
    output logic [AW-1:0]           req_addr_o,
    output logic [LEN_W-1:0]        req_len_o,
    input  logic                    cpl_done_i,
    input  logic                    cpl_err_i,
    output logic                    active_o,
    output logic                    processing_o,
    output seq_evt_t                evt_o
);
    seq_state_e              st_q;
    logic                    active_q, pkt_q, wr_q, raw_q;
    logic [LEN_W-1:0]        len_q;
    logic [AW-1:0]           addr_q;
    logic [OFF_W-1:0]        roff_q;
    logic [AW-1:0]           raddr_q;
    logic [LEN_W-1:0]        rlen_q;
    logic                    rwr_q;
    seq_evt_t                evt_q;
    logic signed [REM_W-1:0] len_s;
    logic [LEN_W-1:0]        raw_len;
    logic                    take;

    assign len_s   = $signed(REM_W'(len_q));
    assign raw_len = (rem_i < len_s) ? rem_i[LEN_W-1:0] : len_q;

    assign chunk_ready_o = (st_q == S_IDLE) && active_q;
    assign take          = chunk_valid_i && chunk_ready_o;
    assign load_o        = start_i && (st_q == S_IDLE);
    assign consume_o     = (st_q == S_EVAL) && !rem_le0_i && (len_q != '0) && !raw_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            active_q <= 1'b0;
            pkt_q    <= 1'b0;
            wr_q     <= 1'b0;
            raw_q    <= 1'b0;
            len_q    <= '0;
            addr_q   <= '0;
            roff_q   <= '0;
            raddr_q  <= '0;
            rlen_q   <= '0;
            rwr_q    <= 1'b0;
            evt_q    <= '0;
        end else begin
            evt_q <= '0;
            case (st_q)
                S_IDLE: begin
                    if (load_o) begin
                        active_q <= 1'b1;
                        pkt_q    <= pkt_i;
                        wr_q     <= wr_i;
                    end
                    if (take) begin
                        len_q  <= chunk_len_i;
                        addr_q <= chunk_addr_i;
                        st_q   <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (rem_le0_i) begin
                        evt_q.dma_end <= 1'b1;
                        evt_q.ok      <= pkt_q;
                        evt_q.irq     <= !pkt_q;
                        active_q      <= 1'b0;
                        st_q          <= S_IDLE;
                    end else if (len_q == '0) begin
                        evt_q.dma_end <= 1'b1;
                        st_q          <= S_IDLE;
                    end else begin
                        raddr_q <= addr_q;
                        raw_q   <= raw_i;
                        len_q   <= '0;
                        st_q    <= S_REQ;
                        if (raw_i) begin
                            roff_q <= '0;
                            rlen_q <= raw_len;
                            rwr_q  <= 1'b0;
                        end else begin
                            roff_q <= off_i;
                            rlen_q <= len_q;
                            rwr_q  <= !pkt_q && wr_q;
                        end
                    end
                end
                S_REQ: begin
                    if (req_ready_i) st_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (cpl_done_i) begin
                        if (cpl_err_i) begin
                            evt_q.dma_end <= 1'b1;
                            evt_q.err     <= 1'b1;
                            active_q      <= 1'b0;
                            st_q          <= S_IDLE;
                        end else if (raw_q) begin
                            evt_q.dma_end <= 1'b1;
                            evt_q.ok      <= 1'b1;
                            active_q      <= 1'b0;
                            st_q          <= S_IDLE;
                        end else begin
                            st_q <= S_EVAL;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign len_o        = len_q;
    assign pkt_o        = pkt_q;
    assign req_valid_o  = (st_q == S_REQ);
    assign req_write_o  = rwr_q;
    assign req_offset_o = roff_q;
    assign req_addr_o   = raddr_q;
    assign req_len_o    = rlen_q;
    assign active_o     = active_q;
    assign processing_o = (st_q != S_IDLE);
    assign evt_o        = evt_q;

endmodule

// File: rtl/xfer_chunk_seq.sv
module xfer_chunk_seq
    import xfer_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEC_W = 28,
    parameter int LBA_W = 32,
    parameter int PKT_W = 24,
    parameter int LEN_W = 16,
    parameter int AW    = 32,
    parameter int OFF_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mode_pkt_i,
    input  logic             dir_wr_i,
    input  logic [CNT_W-1:0] sec_count_i,
    input  logic [SEC_W-1:0] sec_num_i,
    input  logic [PKT_W-1:0] pkt_bytes_i,
    input  logic [LBA_W-1:0] blk_addr_i,
    input  logic             chunk_valid_i,
    output logic             chunk_ready_o,
    input  logic [AW-1:0]    chunk_addr_i,
    input  logic [LEN_W-1:0] chunk_len_i,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    output logic             req_write_o,
    output logic [OFF_W-1:0] req_offset_o,
    output logic [AW-1:0]    req_addr_o,
    output logic [LEN_W-1:0] req_len_o,
    input  logic             cpl_done_i,
    input  logic             cpl_err_i,
    output logic             active_o,
    output logic             processing_o,
    output logic             dma_end_o,
    output logic             drive_irq_o,
    output logic             cmd_ok_o,
    output logic             dma_err_o
);
    localparam int REM_W = max3(CNT_W + SECTOR_SHIFT, PKT_W, LEN_W) + 2;

    logic signed [REM_W-1:0] rem;
    logic [REM_W-1:0]        idx;
    logic                    rem_le0, raw, load, consume, pkt_q;
    logic [LEN_W-1:0]        len_q;
    logic [OFF_W-1:0]        off;
    seq_evt_t                evt;

    xfer_seq_count #(
        .CNT_W(CNT_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .REM_W(REM_W)
    ) u_count (
        .clk(clk), .rst(rst), .load_i(load), .pkt_i(mode_pkt_i),
        .cnt_i(sec_count_i), .pkt_bytes_i(pkt_bytes_i),
        .consume_i(consume), .len_i(len_q),
        .rem_o(rem), .idx_o(idx), .rem_le0_o(rem_le0)
    );

    xfer_seq_offset #(
        .SEC_W(SEC_W), .LBA_W(LBA_W), .REM_W(REM_W), .OFF_W(OFF_W)
    ) u_offset (
        .clk(clk), .rst(rst), .load_i(load), .sec_i(sec_num_i),
        .lba_i(blk_addr_i), .pkt_i(pkt_q), .idx_i(idx),
        .off_o(off), .raw_o(raw)
    );

    xfer_seq_ctrl #(
        .LEN_W(LEN_W), .AW(AW), .REM_W(REM_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .pkt_i(mode_pkt_i),
        .wr_i(dir_wr_i), .chunk_valid_i(chunk_valid_i),
        .chunk_ready_o(chunk_ready_o), .chunk_addr_i(chunk_addr_i),
        .chunk_len_i(chunk_len_i), .rem_i(rem), .rem_le0_i(rem_le0),
        .raw_i(raw), .off_i(off), .load_o(load), .consume_o(consume),
        .len_o(len_q), .pkt_o(pkt_q), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_write_o(req_write_o),
        .req_offset_o(req_offset_o), .req_addr_o(req_addr_o),
        .req_len_o(req_len_o), .cpl_done_i(cpl_done_i),
        .cpl_err_i(cpl_err_i), .active_o(active_o),
        .processing_o(processing_o), .evt_o(evt)
    );

    assign dma_end_o   = evt.dma_end;
    assign drive_irq_o = evt.irq;
    assign cmd_ok_o    = evt.ok;
    assign dma_err_o   = evt.err;

endmodule

// File: rtl/xfer_chunk_seq_chk.sv
module xfer_chunk_seq_chk #(
    parameter int LEN_W = 16,
    parameter int AW    = 32,
    parameter int OFF_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             chunk_ready_o,
    input logic             req_valid_o,
    input logic             req_ready_i,
    input logic             req_write_o,
    input logic [OFF_W-1:0] req_offset_o,
    input logic [AW-1:0]    req_addr_o,
    input logic [LEN_W-1:0] req_len_o,
    input logic             active_o,
    input logic             processing_o,
    input logic             dma_end_o,
    input logic             drive_irq_o,
    input logic             cmd_ok_o,
    input logic             dma_err_o
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_offset_o)
            && $stable(req_addr_o) && $stable(req_len_o) && $stable(req_write_o));

    assert_end_single_R10: assert property (@(posedge clk) disable iff (rst)
        dma_end_o |=> !dma_end_o);

    assert_req_in_pass_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> processing_o);

    assert_ready_armed_R5: assert property (@(posedge clk) disable iff (rst)
        chunk_ready_o |-> active_o && !processing_o);

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drive_irq_o, cmd_ok_o, dma_err_o}));

    assert_outcome_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (drive_irq_o || cmd_ok_o) |-> dma_end_o && !active_o);

    assert_err_ends_R9: assert property (@(posedge clk) disable iff (rst)
        dma_err_o |-> dma_end_o && !active_o);

endmodule

bind xfer_chunk_seq xfer_chunk_seq_chk #(
    .LEN_W(LEN_W), .AW(AW), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .chunk_ready_o(chunk_ready_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_write_o(req_write_o), .req_offset_o(req_offset_o),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .active_o(active_o), .processing_o(processing_o),
    .dma_end_o(dma_end_o), .drive_irq_o(drive_irq_o),
    .cmd_ok_o(cmd_ok_o), .dma_err_o(dma_err_o)
);

// File: tb/test_xfer_chunk_seq.sv
module test_xfer_chunk_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, mode_pkt_i = 0, dir_wr_i = 0;
    logic [15:0] sec_count_i = 0;
    logic [27:0] sec_num_i = 0;
    logic [23:0] pkt_bytes_i = 0;
    logic [31:0] blk_addr_i = 0;
    logic        chunk_valid_i = 0;
    logic        chunk_ready_o;
    logic [31:0] chunk_addr_i = 0;
    logic [15:0] chunk_len_i = 0;
    logic        req_valid_o, req_ready_i = 0, req_write_o;
    logic [47:0] req_offset_o;
    logic [31:0] req_addr_o;
    logic [15:0] req_len_o;
    logic        cpl_done_i = 0, cpl_err_i = 0;
    logic        active_o, processing_o, dma_end_o, drive_irq_o, cmd_ok_o, dma_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xfer_chunk_seq i_xfer_chunk_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_pkt_i(mode_pkt_i),
        .dir_wr_i(dir_wr_i), .sec_count_i(sec_count_i), .sec_num_i(sec_num_i),
        .pkt_bytes_i(pkt_bytes_i), .blk_addr_i(blk_addr_i),
        .chunk_valid_i(chunk_valid_i), .chunk_ready_o(chunk_ready_o),
        .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_write_o(req_write_o), .req_offset_o(req_offset_o),
        .req_addr_o(req_addr_o), .req_len_o(req_len_o),
        .cpl_done_i(cpl_done_i), .cpl_err_i(cpl_err_i),
        .active_o(active_o), .processing_o(processing_o),
        .dma_end_o(dma_end_o), .drive_irq_o(drive_irq_o),
        .cmd_ok_o(cmd_ok_o), .dma_err_o(dma_err_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_start(input bit pkt, input bit wr, input int cnt, input int sec,
                            input int pbytes, input logic [31:0] lba);
        @(negedge clk);
        mode_pkt_i = pkt; dir_wr_i = wr; sec_count_i = 16'(cnt);
        sec_num_i = 28'(sec); pkt_bytes_i = 24'(pbytes); blk_addr_i = lba;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        check("R1 armed after start", active_o, 1);
    endtask

    // Offer one chunk, service any request and check the pass outcome.
    task automatic run_chunk(input string tag, input logic [31:0] addr, input int len,
                             input bit exp_req, input longint exp_off, input bit exp_wr,
                             input int exp_len, input bit err,
                             input bit exp_irq, input bit exp_ok, input bit exp_err);
        bit got_req = 0;
        bit got_end = 0;
        chunk_addr_i = addr; chunk_len_i = 16'(len); chunk_valid_i = 1;
        for (int i = 0; i < 20 && !chunk_ready_o; i++) @(negedge clk);
        check({tag, " chunk taken"}, chunk_ready_o, 1);
        @(negedge clk);
        chunk_valid_i = 0;
        for (int i = 0; i < 20; i++) begin
            if (req_valid_o) begin got_req = 1; break; end
            if (dma_end_o) begin got_end = 1; break; end
            @(negedge clk);
        end
        check({tag, " request issued"}, got_req, exp_req);
        if (got_req) begin
            check({tag, " offset"}, req_offset_o, exp_off);
            check({tag, " write"}, req_write_o, exp_wr);
            check({tag, " length"}, req_len_o, exp_len);
            check({tag, " address"}, req_addr_o, addr);
            @(negedge clk);
            check({tag, " R10 request held"}, req_valid_o, 1);
            req_ready_i = 1;
            @(negedge clk);
            req_ready_i = 0;
            check({tag, " R10 request dropped"}, req_valid_o, 0);
            @(negedge clk);
            cpl_done_i = 1; cpl_err_i = err;
            @(negedge clk);
            cpl_done_i = 0; cpl_err_i = 0;
            for (int i = 0; i < 20 && !dma_end_o; i++) @(negedge clk);
            got_end = dma_end_o;
        end
        check({tag, " R10 dma end"}, got_end, 1);
        check({tag, " irq"}, drive_irq_o, exp_irq);
        check({tag, " cmd ok"}, cmd_ok_o, exp_ok);
        check({tag, " dma err"}, dma_err_o, exp_err);
        @(negedge clk);
        check({tag, " R10 single end pulse"}, dma_end_o, 0);
        check({tag, " armed after pass"}, active_o, !(exp_irq || exp_ok || exp_err));
    endtask

    task automatic t_reset;
        check("reset active", active_o, 0);
        check("reset processing", processing_o, 0);
        check("reset chunk ready", chunk_ready_o, 0);
        check("reset req valid", req_valid_o, 0);
        check("reset dma end", dma_end_o, 0);
    endtask

    // R5 then R1/R2/R4/R6/R11: early chunk, two-sector write split 512+512
    task automatic t_sector_write;
        bit seen = 0;
        chunk_valid_i = 1; chunk_len_i = 512; chunk_addr_i = 32'h1000;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (chunk_ready_o || processing_o || req_valid_o || dma_end_o) seen = 1;
        end
        check("R5 unarmed chunk untouched", seen, 0);
        do_start(0, 1, 2, 5, 0, 0);
        run_chunk("R2 R11 sector first", 32'h1000, 512, 1, 5 * 512, 1, 512, 0, 0, 0, 0);
        run_chunk("R4 R6 sector second", 32'h2000, 512, 1, 5 * 512 + 512, 1, 512, 0, 1, 0, 0);
    endtask

    // R7: zero-length chunk, then the real data
    task automatic t_zero_len;
        do_start(0, 0, 1, 0, 0, 0);
        run_chunk("R7 zero length", 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_chunk("R7 after zero", 32'h3000, 512, 1, 0, 0, 512, 0, 1, 0, 0);
    endtask

    // R6: chunk larger than the command drives remaining negative
    task automatic t_overshoot;
        do_start(0, 0, 1, 100, 0, 0);
        run_chunk("R6 overshoot", 32'h4000, 1024, 1, 100 * 512, 0, 1024, 0, 1, 0, 0);
    endtask

    // R3/R11: packet mode, write request ignored
    task automatic t_packet;
        do_start(1, 1, 0, 0, 4096, 3);
        run_chunk("R3 R11 packet first", 32'h5000, 2048, 1, 3 * 2048, 0, 2048, 0, 0, 0, 0);
        run_chunk("R3 R6 packet second", 32'h5800, 2048, 1, 3 * 2048 + 2048, 0, 2048, 0, 0, 1, 0);
    endtask

    // R8: raw copy clipped to remaining, and clipped to chunk
    task automatic t_raw;
        do_start(1, 0, 0, 0, 100, 32'hFFFF_FFFF);
        run_chunk("R8 raw short size", 32'h6000, 300, 1, 0, 0, 100, 0, 0, 1, 0);
        do_start(1, 0, 0, 0, 500, 32'hFFFF_FFFF);
        run_chunk("R8 raw short chunk", 32'h6400, 200, 1, 0, 0, 200, 0, 0, 1, 0);
    endtask

    // R9: error aborts, further chunks refused
    task automatic t_error;
        bit seen = 0;
        do_start(0, 1, 4, 7, 0, 0);
        run_chunk("R9 error", 32'h7000, 512, 1, 7 * 512, 1, 512, 1, 0, 0, 1);
        chunk_valid_i = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (chunk_ready_o || req_valid_o) seen = 1;
        end
        chunk_valid_i = 0;
        check("R9 R5 no chunk after error", seen, 0);
    endtask

    // R6: remaining already zero when the chunk arrives
    task automatic t_empty_packet;
        do_start(1, 0, 0, 0, 0, 9);
        run_chunk("R6 empty packet", 32'h8000, 64, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_sector_write();
        t_zero_len();
        t_overshoot();
        t_packet();
        t_raw();
        t_error();
        t_empty_packet();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule